// File: doc/BRIEF.md
# Trap Entry State Save Unit

This unit performs every architectural register update that accompanies taking a trap. When the trap-valid input pulses, it does two things in one clock. It stores the interrupted context (program counter, next program counter, hyper state, trap code and a packed saved-state word) into the slot of the next trap level. It also produces the new trap level, global level, processor state, hyper state and current window pointer. Window traps rotate the window pointer. Spill-normal and fill-normal traps also send fetch to a handler start address.

The surrounding pipeline chooses the trap code and presents the current control registers with it. The unit keeps the trap level and the per-level saved registers. Any level's saved registers can be read combinationally through a level-select input. When the trap level is already at its ceiling, the trap is refused and an error pulse is raised.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the trap level is 0 and every output is 0. A trap accepted at the clock edge where the level is below MAX_TL (default 6) raises the level by one, and upd_vld_o is high for exactly the following cycle.
- R2: A trap arriving while the level equals MAX_TL is refused. The level, the held outputs and every slot stay unchanged, upd_vld_o stays low, and tl_err_o is high for the following cycle.
- R3: On acceptance, the slot of the new level (read with rd_lvl_i equal to that level) stores the current PC, NPC, hyper state and 9-bit trap code.
- R4: The saved-state word is 43 bits. It holds the prior global level in bits 42:40, the condition codes in 39:32, the address space identifier in 31:24, the 13-bit processor state in 20:8 and the prior window pointer, zero-extended, in 4:0. All other bits are zero.
- R5: The new global level is the incoming level plus one, limited to MAX_GL (default 3).
- R6: In the new processor state, bit 4 is set and bits 3 and 1 are cleared. Bits 0, 5 to 8 and 10 to 12 pass through unchanged.
- R7: With hyp_dlv_i low (privileged delivery), processor-state bit 2 is set, bit 9 takes the incoming bit 8, and the hyper state passes through unchanged.
- R8: With hyp_dlv_i high, processor-state bits 2 and 9 are cleared. In the hyper state, bit 5 is cleared, bit 2 is set and bit 10 is cleared; the other hyper-state bits pass through.
- R9: The window pointer changes modulo NWIN (default 8) according to the trap code, and cwp_wr_o pulses only when one of the three rotating cases applies. Code 0x024 adds one. Codes 0x080 to 0x0BF add the save count plus two. Codes 0x0C0 to 0x0FF subtract one. Any other code leaves the pointer unchanged.
- R10: Codes 0x080 to 0x09F redirect fetch to spill_base_i, and codes 0x0C0 to 0x0DF redirect fetch to fill_base_i. On a redirect, redir_o pulses with the next PC at base+4 and the one after at base+8. No other code redirects.
- R11: In cycles without an accepted trap, the global level, processor state, hyper state and window pointer outputs hold their values. Slots of other levels keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_vld_i | input | 1 | Trap taken this cycle |
| trap_code_i | input | 9 | Trap type code |
| hyp_dlv_i | input | 1 | 1: hyperprivileged delivery, 0: privileged |
| pc_i | input | AW | Current PC |
| npc_i | input | AW | Current next PC |
| gl_i | input | 3 | Current global level |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Address space identifier |
| pstate_i | input | 13 | Current processor state |
| hstate_i | input | 12 | Current hyper state |
| cwp_i | input | log2(NWIN) | Current window pointer |
| savecnt_i | input | log2(NWIN) | Saveable window count |
| spill_base_i | input | AW | Spill handler start |
| fill_base_i | input | AW | Fill handler start |
| rd_lvl_i | input | log2(MAX_TL+1) | Slot level to read (1..MAX_TL) |
| tl_o | output | log2(MAX_TL+1) | Trap level |
| upd_vld_o | output | 1 | Update committed last edge |
| tl_err_o | output | 1 | Trap refused at maximum level |
| gl_o | output | 3 | New global level |
| pstate_o | output | 13 | New processor state |
| hstate_o | output | 12 | New hyper state |
| cwp_o | output | log2(NWIN) | New window pointer |
| cwp_wr_o | output | 1 | Window pointer rotated |
| redir_o | output | 1 | Fetch redirect |
| redir_pc_o | output | AW | Redirect PC |
| redir_npc_o | output | AW | Redirect next PC |
| redir_nnpc_o | output | AW | Redirect next-next PC |
| rd_tpc_o | output | AW | Saved PC of selected level |
| rd_tnpc_o | output | AW | Saved NPC of selected level |
| rd_tstate_o | output | 43 | Saved-state word of selected level |
| rd_htstate_o | output | 12 | Saved hyper state of selected level |
| rd_tt_o | output | 9 | Saved trap code of selected level |

## Verification
Spill-normal and fill-normal traps rotate the window pointer and redirect fetch in the same commit cycle. The directed cases include a spill-normal trap whose sum wraps past the top window and a fill-normal trap at window zero that wraps downward. The random stream also favours the window ranges. In each such cycle the bench compares the rotated pointer, cwp_wr_o, redir_o and the three redirect addresses against its own model. The refusal at the top level is provoked with window and redirect codes, so it is confirmed that neither function fires on a refused trap.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef logic [8:0]  tt_t;
  typedef logic [12:0] pst_t;
  typedef logic [11:0] hst_t;
  typedef logic [42:0] tstate_t;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_CLEAN = 2'd1,
    WIN_SPILL = 2'd2,
    WIN_FILL  = 2'd3
  } win_cls_e;

  // window behaviour selected by code range
  function automatic win_cls_e classify_win(tt_t tt);
    if (tt == 9'h024)           return WIN_CLEAN;
    else if (tt[8:6] == 3'b010) return WIN_SPILL;
    else if (tt[8:6] == 3'b011) return WIN_FILL;
    else                        return WIN_NONE;
  endfunction

  function automatic logic is_spill_normal(tt_t tt);
    return tt[8:5] == 4'b0100;
  endfunction

  function automatic logic is_fill_normal(tt_t tt);
    return tt[8:5] == 4'b0110;
  endfunction

  function automatic tstate_t pack_tstate(logic [2:0] gl, logic [7:0] ccr,
                                          logic [7:0] asi, pst_t pst,
                                          logic [4:0] cwp);
    tstate_t w;
    w        = '0;
    w[4:0]   = cwp;
    w[20:8]  = pst;
    w[31:24] = asi;
    w[39:32] = ccr;
    w[42:40] = gl;
    return w;
  endfunction

  function automatic pst_t pstate_on_entry(pst_t p, logic hyp);
    pst_t r;
    r    = p;
    r[4] = 1'b1;
    r[3] = 1'b0;
    r[1] = 1'b0;
    if (hyp) begin
      r[2] = 1'b0;
      r[9] = 1'b0;
    end else begin
      r[2] = 1'b1;
      r[9] = p[8];
    end
    return r;
  endfunction

  function automatic hst_t hstate_on_entry(hst_t h, logic hyp);
    hst_t r;
    r = h;
    if (hyp) begin
      r[5]  = 1'b0;
      r[2]  = 1'b1;
      r[10] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [2:0] gl_on_entry(logic [2:0] gl, int unsigned max_gl);
    int unsigned n;
    n = 32'(gl) + 32'd1;
    if (n > max_gl) n = max_gl;
    return 3'(n);
  endfunction

  function automatic logic [4:0] cwp_on_entry(logic [4:0] cwp, logic [4:0] save,
                                              win_cls_e cls, int unsigned nwin);
    int unsigned s;
    case (cls)
      WIN_CLEAN: s = 32'(cwp) + 32'd1;
      WIN_SPILL: s = 32'(cwp) + 32'(save) + 32'd2;
      WIN_FILL:  s = 32'(cwp) + nwin - 32'd1;
      default:   s = 32'(cwp);
    endcase
    return 5'(s % nwin);
  endfunction

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
  parameter int MAX_TL = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           trap_vld,
  output logic [$clog2(MAX_TL+1)-1:0]    tl_o,
  output logic                           accept_o,
  output logic                           sat_o,
  output logic                           upd_vld_o,
  output logic                           err_o
);
  localparam int TL_W = $clog2(MAX_TL+1);
  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

  logic at_top;
  assign at_top   = (tl_o == TL_TOP);
  assign accept_o = trap_vld && !at_top;
  assign sat_o    = trap_vld && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_o      <= '0;
      upd_vld_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      upd_vld_o <= accept_o;
      err_o     <= sat_o;
      if (accept_o) tl_o <= tl_o + 1'b1;
    end
  end
endmodule

// File: rtl/trap_slot_file.sv
module trap_slot_file
  import trap_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int AW     = 64,
  parameter int TL_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [TL_W-1:0] wr_lvl,
  input  logic [AW-1:0]   wr_pc,
  input  logic [AW-1:0]   wr_npc,
  input  tstate_t         wr_tstate,
  input  hst_t            wr_htstate,
  input  tt_t             wr_tt,
  input  logic [TL_W-1:0] rd_lvl,
  output logic [AW-1:0]   rd_pc,
  output logic [AW-1:0]   rd_npc,
  output tstate_t         rd_tstate,
  output hst_t            rd_htstate,
  output tt_t             rd_tt
);
  typedef struct packed {
    logic [AW-1:0] pc;
    logic [AW-1:0] npc;
    tstate_t       ts;
    hst_t          hs;
    tt_t           tt;
  } slot_t;

  slot_t wr_slot;
  slot_t rd_slot;
  slot_t slot_w [MAX_TL];

  assign wr_slot = '{pc: wr_pc, npc: wr_npc, ts: wr_tstate, hs: wr_htstate, tt: wr_tt};

  for (genvar g = 0; g < MAX_TL; g++) begin : g_slot
    localparam logic [TL_W-1:0] LVL = TL_W'(g + 1);
    slot_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q <= '0;
      else if (we && wr_lvl == LVL)  q <= wr_slot;
    end
    assign slot_w[g] = q;
  end

  always_comb begin
    rd_slot = '0;
    for (int i = 0; i < MAX_TL; i++)
      if (rd_lvl == TL_W'(i + 1)) rd_slot = slot_w[i];
  end

  assign rd_pc      = rd_slot.pc;
  assign rd_npc     = rd_slot.npc;
  assign rd_tstate  = rd_slot.ts;
  assign rd_htstate = rd_slot.hs;
  assign rd_tt      = rd_slot.tt;
endmodule

// File: rtl/trap_ctx_update.sv
module trap_ctx_update
  import trap_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MAX_GL = 3,
  parameter int AW     = 64,
  parameter int CWP_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             hyp,
  input  win_cls_e         win_cls,
  input  logic             redir_hit,
  input  logic [AW-1:0]    redir_base,
  input  logic [2:0]       gl_i,
  input  pst_t             pstate_i,
  input  hst_t             hstate_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] save_i,
  output logic [2:0]       gl_o,
  output pst_t             pstate_o,
  output hst_t             hstate_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic             cwp_wr_o,
  output logic             redir_o,
  output logic [AW-1:0]    redir_pc_o,
  output logic [AW-1:0]    redir_npc_o,
  output logic [AW-1:0]    redir_nnpc_o
);
  logic [4:0] cwp_next;
  assign cwp_next = cwp_on_entry(5'(cwp_i), 5'(save_i), win_cls, NWIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gl_o         <= '0;
      pstate_o     <= '0;
      hstate_o     <= '0;
      cwp_o        <= '0;
      cwp_wr_o     <= 1'b0;
      redir_o      <= 1'b0;
      redir_pc_o   <= '0;
      redir_npc_o  <= '0;
      redir_nnpc_o <= '0;
    end else begin
      cwp_wr_o <= accept && (win_cls != WIN_NONE);
      redir_o  <= accept && redir_hit;
      if (accept) begin
        gl_o     <= gl_on_entry(gl_i, MAX_GL);
        pstate_o <= pstate_on_entry(pstate_i, hyp);
        hstate_o <= hstate_on_entry(hstate_i, hyp);
        cwp_o    <= CWP_W'(cwp_next);
        if (redir_hit) begin
          redir_pc_o   <= redir_base;
          redir_npc_o  <= redir_base + AW'(4);
          redir_nnpc_o <= redir_base + AW'(8);
        end
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int AW     = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           trap_vld_i,
  input  logic [8:0]                     trap_code_i,
  input  logic                           hyp_dlv_i,
  input  logic [AW-1:0]                  pc_i,
  input  logic [AW-1:0]                  npc_i,
  input  logic [2:0]                     gl_i,
  input  logic [7:0]                     ccr_i,
  input  logic [7:0]                     asi_i,
  input  logic [12:0]                    pstate_i,
  input  logic [11:0]                    hstate_i,
  input  logic [$clog2(NWIN)-1:0]        cwp_i,
  input  logic [$clog2(NWIN)-1:0]        savecnt_i,
  input  logic [AW-1:0]                  spill_base_i,
  input  logic [AW-1:0]                  fill_base_i,
  input  logic [$clog2(MAX_TL+1)-1:0]    rd_lvl_i,
  output logic [$clog2(MAX_TL+1)-1:0]    tl_o,
  output logic                           upd_vld_o,
  output logic                           tl_err_o,
  output logic [2:0]                     gl_o,
  output logic [12:0]                    pstate_o,
  output logic [11:0]                    hstate_o,
  output logic [$clog2(NWIN)-1:0]        cwp_o,
  output logic                           cwp_wr_o,
  output logic                           redir_o,
  output logic [AW-1:0]                  redir_pc_o,
  output logic [AW-1:0]                  redir_npc_o,
  output logic [AW-1:0]                  redir_nnpc_o,
  output logic [AW-1:0]                  rd_tpc_o,
  output logic [AW-1:0]                  rd_tnpc_o,
  output logic [42:0]                    rd_tstate_o,
  output logic [11:0]                    rd_htstate_o,
  output logic [8:0]                     rd_tt_o
);
  localparam int TL_W  = $clog2(MAX_TL+1);
  localparam int CWP_W = $clog2(NWIN);

  // named internal events
  logic            trap_accept;
  logic            trap_sat;
  logic            redir_hit;
  win_cls_e        win_cls;
  logic [AW-1:0]   redir_base;
  logic [TL_W-1:0] tl_new;
  tstate_t         saved_word;

  assign win_cls    = classify_win(trap_code_i);
  assign redir_hit  = is_spill_normal(trap_code_i) || is_fill_normal(trap_code_i);
  assign redir_base = is_spill_normal(trap_code_i) ? spill_base_i : fill_base_i;
  assign tl_new     = tl_o + 1'b1;
  assign saved_word = pack_tstate(gl_i, ccr_i, asi_i, pstate_i, 5'(cwp_i));

  trap_level_ctl #(.MAX_TL(MAX_TL)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_vld  (trap_vld_i),
    .tl_o      (tl_o),
    .accept_o  (trap_accept),
    .sat_o     (trap_sat),
    .upd_vld_o (upd_vld_o),
    .err_o     (tl_err_o)
  );

  trap_slot_file #(.MAX_TL(MAX_TL), .AW(AW), .TL_W(TL_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (trap_accept),
    .wr_lvl     (tl_new),
    .wr_pc      (pc_i),
    .wr_npc     (npc_i),
    .wr_tstate  (saved_word),
    .wr_htstate (hstate_i),
    .wr_tt      (trap_code_i),
    .rd_lvl     (rd_lvl_i),
    .rd_pc      (rd_tpc_o),
    .rd_npc     (rd_tnpc_o),
    .rd_tstate  (rd_tstate_o),
    .rd_htstate (rd_htstate_o),
    .rd_tt      (rd_tt_o)
  );

  trap_ctx_update #(.NWIN(NWIN), .MAX_GL(MAX_GL), .AW(AW), .CWP_W(CWP_W)) u_ctx (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (trap_accept),
    .hyp          (hyp_dlv_i),
    .win_cls      (win_cls),
    .redir_hit    (redir_hit),
    .redir_base   (redir_base),
    .gl_i         (gl_i),
    .pstate_i     (pstate_i),
    .hstate_i     (hstate_i),
    .cwp_i        (cwp_i),
    .save_i       (savecnt_i),
    .gl_o         (gl_o),
    .pstate_o     (pstate_o),
    .hstate_o     (hstate_o),
    .cwp_o        (cwp_o),
    .cwp_wr_o     (cwp_wr_o),
    .redir_o      (redir_o),
    .redir_pc_o   (redir_pc_o),
    .redir_npc_o  (redir_npc_o),
    .redir_nnpc_o (redir_nnpc_o)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int NWIN   = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int AW     = 64,
  parameter int TL_W   = 3,
  parameter int CWP_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             sat,
  input logic [TL_W-1:0]  tl,
  input logic             upd_vld,
  input logic             tl_err,
  input logic [2:0]       gl,
  input logic [12:0]      pstate,
  input logic [11:0]      hstate,
  input logic [CWP_W-1:0] cwp,
  input logic             cwp_wr,
  input logic             redir,
  input logic [AW-1:0]    rpc,
  input logic [AW-1:0]    rnpc,
  input logic [AW-1:0]    rnnpc
);
  assert_tl_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tl == TL_W'($past(tl) + 1'b1)) && upd_vld);

  assert_sat_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sat |=> tl_err && !upd_vld && $stable(tl));

  assert_tl_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tl) <= MAX_TL);

  assert_gl_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |-> 32'(gl) <= MAX_GL);

  assert_pst_common_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |-> pstate[4] && !pstate[3] && !pstate[1]);

  assert_cwp_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cwp) < NWIN);

  assert_cwp_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_wr |-> upd_vld);

  assert_redir_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redir |-> upd_vld && (rnpc == rpc + AW'(4)) && (rnnpc == rpc + AW'(8)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |-> $stable(gl) && $stable(pstate) && $stable(hstate) && $stable(cwp));
endmodule

bind trap_entry_unit trap_entry_chk #(
  .NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .AW(AW), .TL_W(TL_W), .CWP_W(CWP_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .accept  (trap_accept),
  .sat     (trap_sat),
  .tl      (tl_o),
  .upd_vld (upd_vld_o),
  .tl_err  (tl_err_o),
  .gl      (gl_o),
  .pstate  (pstate_o),
  .hstate  (hstate_o),
  .cwp     (cwp_o),
  .cwp_wr  (cwp_wr_o),
  .redir   (redir_o),
  .rpc     (redir_pc_o),
  .rnpc    (redir_npc_o),
  .rnnpc   (redir_nnpc_o)
);

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN   = 8;
  localparam int MAX_TL = 6;
  localparam int MAX_GL = 3;
  localparam int AW     = 64;
  localparam int TL_W   = $clog2(MAX_TL+1);
  localparam int CWP_W  = $clog2(NWIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_vld = 1'b0;
  logic [8:0] code = '0;
  logic hyp = 1'b0;
  logic [AW-1:0] pc = '0, npc = '0, sbase = '0, fbase = '0;
  logic [2:0] gl = '0;
  logic [7:0] ccr = '0, asi = '0;
  logic [12:0] pst = '0;
  logic [11:0] hst = '0;
  logic [CWP_W-1:0] cwp = '0, save = '0;
  logic [TL_W-1:0] rd_lvl = '0;

  logic [TL_W-1:0] tl_o;
  logic upd_o, err_o, cwp_wr_o, redir_o;
  logic [2:0] gl_o;
  logic [12:0] pst_o;
  logic [11:0] hst_o;
  logic [CWP_W-1:0] cwp_o;
  logic [AW-1:0] rpc_o, rnpc_o, rnnpc_o, tpc_o, tnpc_o;
  logic [42:0] tstate_o;
  logic [11:0] htstate_o;
  logic [8:0] tt_o;

  trap_entry_unit #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .trap_vld_i(trap_vld), .trap_code_i(code), .hyp_dlv_i(hyp),
    .pc_i(pc), .npc_i(npc), .gl_i(gl), .ccr_i(ccr), .asi_i(asi), .pstate_i(pst),
    .hstate_i(hst), .cwp_i(cwp), .savecnt_i(save), .spill_base_i(sbase), .fill_base_i(fbase),
    .rd_lvl_i(rd_lvl), .tl_o(tl_o), .upd_vld_o(upd_o), .tl_err_o(err_o), .gl_o(gl_o),
    .pstate_o(pst_o), .hstate_o(hst_o), .cwp_o(cwp_o), .cwp_wr_o(cwp_wr_o), .redir_o(redir_o),
    .redir_pc_o(rpc_o), .redir_npc_o(rnpc_o), .redir_nnpc_o(rnnpc_o), .rd_tpc_o(tpc_o),
    .rd_tnpc_o(tnpc_o), .rd_tstate_o(tstate_o), .rd_htstate_o(htstate_o), .rd_tt_o(tt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int e_tl;
  logic [AW-1:0] e_pc [1:MAX_TL];
  logic [AW-1:0] e_npc [1:MAX_TL];
  logic [42:0]   e_ts [1:MAX_TL];
  logic [11:0]   e_hs [1:MAX_TL];
  logic [8:0]    e_tt [1:MAX_TL];
  logic [2:0]  e_gl;
  logic [12:0] e_pst;
  logic [11:0] e_hst;
  int          e_cwp;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [42:0] m_tstate(logic [2:0] g, logic [7:0] c, logic [7:0] a,
                                           logic [12:0] p, int w);
    return {g, c, a, 3'b000, p, 3'b000, 5'(w)};
  endfunction

  function automatic logic [12:0] m_pst(logic [12:0] p, logic h);
    logic [12:0] r;
    r = (p & ~13'h21E) | 13'h010;       // clear 9,4,3,2,1 then set 4
    if (!h) r = r | 13'h004 | (13'(p[8]) << 9);
    return r;
  endfunction

  function automatic logic [11:0] m_hst(logic [11:0] p, logic h);
    return h ? ((p & ~12'h420) | 12'h004) : p;
  endfunction

  function automatic int m_cwp(int w, int s, int t);
    int d;
    if (t == 'h24) d = 1;
    else if (t >= 'h80 && t <= 'hBF) d = s + 2;
    else if (t >= 'hC0 && t <= 'hFF) d = -1;
    else d = 0;
    return ((w + d) % NWIN + NWIN) % NWIN;
  endfunction

  function automatic bit m_rot(int t);
    return t == 'h24 || (t >= 'h80 && t <= 'hFF);
  endfunction

  task automatic model_reset();
    e_tl = 0; e_gl = '0; e_pst = '0; e_hst = '0; e_cwp = 0;
    for (int i = 1; i <= MAX_TL; i++) begin
      e_pc[i] = '0; e_npc[i] = '0; e_ts[i] = '0; e_hs[i] = '0; e_tt[i] = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    trap_vld = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_slot(int lvl, string tag);
    rd_lvl = TL_W'(lvl);
    #1;
    chk({tag, " tpc"},     tpc_o, e_pc[lvl]);
    chk({tag, " tnpc"},    tnpc_o, e_npc[lvl]);
    chk({tag, " tstate"},  64'(tstate_o), 64'(e_ts[lvl]));
    chk({tag, " htstate"}, 64'(htstate_o), 64'(e_hs[lvl]));
    chk({tag, " tt"},      64'(tt_o), 64'(e_tt[lvl]));
  endtask

  task automatic check_held(string tag);
    chk({tag, " gl"},    64'(gl_o), 64'(e_gl));
    chk({tag, " pstate"}, 64'(pst_o), 64'(e_pst));
    chk({tag, " hstate"}, 64'(hst_o), 64'(e_hst));
    chk({tag, " cwp"},   64'(cwp_o), 64'(e_cwp));
  endtask

  task automatic set_ctx(int t, bit h, int g, int w, int s);
    code = 9'(t); hyp = h; gl = 3'(g); cwp = CWP_W'(w); save = CWP_W'(s);
    pc = {$urandom, $urandom}; npc = pc + 64'd4;
    ccr = 8'($urandom); asi = 8'($urandom);
    pst = 13'($urandom); hst = 12'($urandom);
    sbase = {$urandom, $urandom & 32'hFFFF_FFFC};
    fbase = {$urandom, $urandom & 32'hFFFF_FFFC};
  endtask

  // one trap pulse, then compare at the following negedge
  task automatic apply_trap();
    bit acc, rd;
    int t;
    logic [AW-1:0] base;
    t = int'(code);
    @(negedge clk);
    trap_vld = 1'b1;
    @(negedge clk);
    trap_vld = 1'b0;
    acc = (e_tl < MAX_TL);
    rd  = (t >= 'h80 && t <= 'h9F) || (t >= 'hC0 && t <= 'hDF);
    base = (t <= 'h9F) ? sbase : fbase;
    if (acc) begin
      e_tl++;
      e_pc[e_tl] = pc; e_npc[e_tl] = npc; e_hs[e_tl] = hst; e_tt[e_tl] = code;
      e_ts[e_tl] = m_tstate(gl, ccr, asi, pst, int'(cwp));
      e_gl  = (int'(gl) + 1 > MAX_GL) ? 3'(MAX_GL) : gl + 3'd1;
      e_pst = m_pst(pst, hyp);
      e_hst = m_hst(hst, hyp);
      e_cwp = m_cwp(int'(cwp), int'(save), t);
      chk("R1 tl", 64'(tl_o), 64'(e_tl));
      chk("R1 upd_vld", 64'(upd_o), 64'd1);
      chk("R2 no err", 64'(err_o), 64'd0);
      chk("R5 gl", 64'(gl_o), 64'(e_gl));
      chk(hyp ? "R8 pstate" : "R6 R7 pstate", 64'(pst_o), 64'(e_pst));
      chk(hyp ? "R8 hstate" : "R7 hstate", 64'(hst_o), 64'(e_hst));
      chk("R9 cwp", 64'(cwp_o), 64'(e_cwp));
      chk("R9 cwp_wr", 64'(cwp_wr_o), 64'(m_rot(t)));
      chk("R10 redir", 64'(redir_o), 64'(rd));
      if (rd) begin
        chk("R10 pc", rpc_o, base);
        chk("R10 npc", rnpc_o, base + 64'd4);
        chk("R10 nnpc", rnnpc_o, base + 64'd8);
      end
      check_slot(e_tl, "R3 R4 slot");
      if (e_tl > 1) check_slot(e_tl - 1, "R11 lower slot");
    end else begin
      chk("R2 tl held", 64'(tl_o), 64'(MAX_TL));
      chk("R2 err", 64'(err_o), 64'd1);
      chk("R2 upd_vld", 64'(upd_o), 64'd0);
      chk("R2 redir", 64'(redir_o), 64'd0);
      chk("R2 cwp_wr", 64'(cwp_wr_o), 64'd0);
      check_held("R2 held");
      check_slot(MAX_TL, "R2 slot kept");
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R11 upd idle", 64'(upd_o), 64'd0);
    chk("R11 err idle", 64'(err_o), 64'd0);
    check_held("R11 hold");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 reset tl", 64'(tl_o), 64'd0);
    chk("R1 reset upd", 64'(upd_o), 64'd0);
    chk("R1 reset err", 64'(err_o), 64'd0);
    chk("R10 reset redir", 64'(redir_o), 64'd0);
    check_held("R1 reset");

    // directed: window and redirect ranges, wraps, both delivery modes
    set_ctx('h024, 1'b0, 0, 7, 3); apply_trap();   // R9 clean wrap 7->0
    set_ctx('h085, 1'b0, 2, 6, 7); apply_trap();   // R9 R10 spill normal, 6+9 wraps to 7
    set_ctx('h0C2, 1'b1, 3, 0, 1); apply_trap();   // R9 R10 fill normal, 0 wraps to 7, gl capped R5
    set_ctx('h0A3, 1'b1, 7, 4, 2); apply_trap();   // R9 spill other, no redirect
    idle_check();
    set_ctx('h0E7, 1'b0, 1, 5, 0); apply_trap();   // R9 fill other
    set_ctx('h041, 1'b1, 2, 3, 5); apply_trap();   // R9 no rotation
    // R2: refusal with window and redirect codes
    set_ctx('h09F, 1'b0, 0, 2, 2); apply_trap();
    set_ctx('h0DF, 1'b1, 0, 2, 2); apply_trap();
    idle_check();

    // random phase
    do_reset();
    for (int k = 0; k < 600; k++) begin
      int sel, t;
      sel = $urandom_range(0, 5);
      case (sel)
        0: t = 'h24;
        1: t = $urandom_range('h80, 'h9F);
        2: t = $urandom_range('hA0, 'hBF);
        3: t = $urandom_range('hC0, 'hDF);
        4: t = $urandom_range('hE0, 'hFF);
        default: t = $urandom_range(0, 'h1FF);
      endcase
      set_ctx(t, 1'($urandom), $urandom_range(0, 7),
              $urandom_range(0, NWIN-1), $urandom_range(0, NWIN-1));
      apply_trap();
      if ($urandom_range(0, 3) == 0) idle_check();
      if (e_tl == MAX_TL && $urandom_range(0, 2) == 0) do_reset();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule